// File: doc/BRIEF.md
# Auto-Reload Tick Timer with Single-Shot Mode

This block is an up-counting timer that sits on a simple register bus and produces a periodic or single-shot tick interrupt. A prescaler divides the input clock. Each prescaler tick advances the counter. When the counter reaches the active reload value, it wraps to zero and raises an update flag. When interrupts are enabled, the flag drives the interrupt output.

The reload value can be written straight into the active register. It can also be held in a shadow copy that moves into the active register only at the next update event. Software can force an update event. That event moves the shadowed prescaler and reload values into the active registers, clears both counters and sets the flag. In single-shot mode the timer clears its own run bit at the first wrap.

The counter width `CNT_W` is 16 or 32. Software detects the width by writing all ones to the reload register and reading the value back.

Top module: `tick_timer`

## Requirements
- R1: After reset, every readable register reads 0 and `irq` is 0.
- R2: With divider value P and active reload value A, the first wrap after the run bit is set comes (A+1)*(P+1) clocks after the write that set it.
- R3: With single-shot clear (control bit 3 = 0), a wrap sets the status flag (status bit 0). The counter returns to 0 and the run bit (control bit 0) stays set.
- R4: With single-shot set (control bit 3 = 1), the wrap sets the flag and clears the run bit in the same cycle. The control register then reads 0x08 and the counter reads 0.
- R5: With preload set (control bit 7 = 1), a write to the reload register changes only the shadow copy. The shadow reads back at once, and the running period changes only after the next update event. With preload clear, the write takes effect at once.
- R6: Writing 1 to bit 0 of the event register (address 3) clears the counter and the prescaler count, loads the shadowed divider and reload values, and sets the status flag. The event register reads 0.
- R7: `irq` is 1 exactly when the status flag and the interrupt-enable bit (address 1, bit 0) are both 1. A status write with bit 0 = 0 clears the flag.
- R8: Writing all ones to the reload register (address 5) reads back as 2^CNT_W - 1.
- R9: Writing 0 to the control register stops the counter, and the counter holds its value.
- R10: The register addresses are: control 0, interrupt enable 1, status 2, event 3, divider 4, reload 5, counter 6. Bits that hold no field read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| bus_addr | input | 3 | Register word address |
| bus_wdata | input | 32 | Write data |
| bus_wr | input | 1 | Write strobe, one write per cycle |
| bus_rd | input | 1 | Read strobe; `bus_rdata` is valid the cycle after |
| bus_rdata | output | 32 | Registered read data |
| irq | output | 1 | Update interrupt |

## Verification
The assertions assume that the bus makes at most one access per cycle and that the address is stable while a strobe is high. They also assume that software does not write the control register in the same cycle as a single-shot wrap. The stimulus drives each access for exactly one cycle on the falling clock edge. It always stops the timer, or waits for the interrupt, before it changes control, so no control write lands on a wrap cycle.

// File: rtl/tt_pkg.sv
package tt_pkg;
  localparam int BUS_W  = 32;
  localparam int ADDR_W = 3;

  localparam logic [ADDR_W-1:0] A_CTRL = 3'd0;
  localparam logic [ADDR_W-1:0] A_IEN  = 3'd1;
  localparam logic [ADDR_W-1:0] A_STAT = 3'd2;
  localparam logic [ADDR_W-1:0] A_EVT  = 3'd3;
  localparam logic [ADDR_W-1:0] A_DIV  = 3'd4;
  localparam logic [ADDR_W-1:0] A_RLD  = 3'd5;
  localparam logic [ADDR_W-1:0] A_CNT  = 3'd6;

  localparam int B_RUN  = 0;
  localparam int B_ONE  = 3;
  localparam int B_PRE  = 7;
endpackage

// File: rtl/tt_prescaler.sv
module tt_prescaler #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             force_upd,
  input  logic [DIV_W-1:0] div_act,
  output logic             tick
);
  logic [DIV_W-1:0] pc_q, pc_d;

  assign tick = run && (pc_q == div_act);

  always_comb begin
    pc_d = pc_q;
    if (force_upd)  pc_d = '0;
    else if (tick)  pc_d = '0;
    else if (run)   pc_d = pc_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pc_q <= '0;
    else        pc_q <= pc_d;
  end

  // R9
  pc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !force_upd) |=> $stable(pc_q));

  // R6
  pc_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    force_upd |=> (pc_q == '0));
endmodule

// File: rtl/tt_counter.sv
module tt_counter #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             force_upd,
  input  logic [CNT_W-1:0] rld_act,
  output logic [CNT_W-1:0] cnt,
  output logic             wrap
);
  logic [CNT_W-1:0] cnt_q, cnt_d;

  assign wrap = tick && (cnt_q == rld_act);
  assign cnt  = cnt_q;

  always_comb begin
    cnt_d = cnt_q;
    if (force_upd)  cnt_d = '0;
    else if (wrap)  cnt_d = '0;
    else if (tick)  cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // R2
  cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !wrap && !force_upd) |=> (cnt_q == $past(cnt_q) + 1'b1));

  // R3
  cnt_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wrap || force_upd) |=> (cnt_q == '0));

  // R9
  cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !force_upd) |=> $stable(cnt_q));
endmodule

// File: rtl/tt_regs.sv
module tt_regs
  import tt_pkg::*;
#(
  parameter int CNT_W = 32,
  parameter int DIV_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic              rd,
  input  logic [ADDR_W-1:0] addr,
  input  logic [BUS_W-1:0]  wdata,
  output logic [BUS_W-1:0]  rdata,
  input  logic              wrap,
  input  logic [CNT_W-1:0]  cnt,
  output logic              run,
  output logic              force_upd,
  output logic [DIV_W-1:0]  div_act,
  output logic [CNT_W-1:0]  rld_act,
  output logic              irq
);
  logic             run_q, run_d, one_q, one_d, pre_q, pre_d;
  logic             ien_q, ien_d, flag_q, flag_d;
  logic [DIV_W-1:0] div_sh_q, div_sh_d, div_act_q, div_act_d;
  logic [CNT_W-1:0] rld_sh_q, rld_sh_d, rld_act_q, rld_act_d;
  logic [BUS_W-1:0] rdata_q, rdata_d;
  logic             ctrl_wr;

  assign ctrl_wr   = wr && (addr == A_CTRL);
  assign force_upd = wr && (addr == A_EVT) && wdata[0];

  always_comb begin
    run_d     = run_q;
    one_d     = one_q;
    pre_d     = pre_q;
    ien_d     = ien_q;
    flag_d    = flag_q;
    div_sh_d  = div_sh_q;
    div_act_d = div_act_q;
    rld_sh_d  = rld_sh_q;
    rld_act_d = rld_act_q;
    if (wr) begin
      case (addr)
        A_CTRL: begin
          run_d = wdata[B_RUN];
          one_d = wdata[B_ONE];
          pre_d = wdata[B_PRE];
        end
        A_IEN:  ien_d = wdata[0];
        A_STAT: if (!wdata[0]) flag_d = 1'b0;
        A_DIV:  div_sh_d = wdata[DIV_W-1:0];
        A_RLD: begin
          rld_sh_d = wdata[CNT_W-1:0];
          if (!pre_q) rld_act_d = wdata[CNT_W-1:0];
        end
        default: ;
      endcase
    end
    if (wrap && one_q && !ctrl_wr) run_d = 1'b0;
    if (wrap || force_upd) begin
      flag_d    = 1'b1;
      div_act_d = div_sh_d;
      rld_act_d = rld_sh_d;
    end
  end

  always_comb begin
    rdata_d = '0;
    case (addr)
      A_CTRL: begin
        rdata_d[B_RUN] = run_q;
        rdata_d[B_ONE] = one_q;
        rdata_d[B_PRE] = pre_q;
      end
      A_IEN:  rdata_d[0] = ien_q;
      A_STAT: rdata_d[0] = flag_q;
      A_DIV:  rdata_d[DIV_W-1:0] = div_sh_q;
      A_RLD:  rdata_d[CNT_W-1:0] = rld_sh_q;
      A_CNT:  rdata_d[CNT_W-1:0] = cnt;
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q     <= 1'b0;
      one_q     <= 1'b0;
      pre_q     <= 1'b0;
      ien_q     <= 1'b0;
      flag_q    <= 1'b0;
      div_sh_q  <= '0;
      div_act_q <= '0;
      rld_sh_q  <= '0;
      rld_act_q <= '0;
    end else begin
      run_q     <= run_d;
      one_q     <= one_d;
      pre_q     <= pre_d;
      ien_q     <= ien_d;
      flag_q    <= flag_d;
      div_sh_q  <= div_sh_d;
      div_act_q <= div_act_d;
      rld_sh_q  <= rld_sh_d;
      rld_act_q <= rld_act_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  rdata_q <= '0;
    else if (rd) rdata_q <= rdata_d;
  end

  assign rdata   = rdata_q;
  assign run     = run_q;
  assign div_act = div_act_q;
  assign rld_act = rld_act_q;
  assign irq     = flag_q && ien_q;

  // R3
  wrap_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wrap |=> flag_q);

  // R4
  one_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wrap && one_q && !ctrl_wr) |=> !run_q);

  // R5
  shadow_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pre_q && !wrap && !force_upd) |=> $stable(rld_act_q));

  // R6
  evt_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    force_upd |=> (flag_q && (rld_act_q == rld_sh_q) && (div_act_q == div_sh_q)));
endmodule

// File: rtl/tick_timer.sv
module tick_timer
  import tt_pkg::*;
#(
  parameter int CNT_W = 32,
  parameter int DIV_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [BUS_W-1:0]  bus_wdata,
  input  logic              bus_wr,
  input  logic              bus_rd,
  output logic [BUS_W-1:0]  bus_rdata,
  output logic              irq
);
  logic [1:0]       rst_sync_q;
  logic             rst_ni;
  logic             run, force_upd, tick, wrap;
  logic [DIV_W-1:0] div_act;
  logic [CNT_W-1:0] rld_act, cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_ni = rst_sync_q[1];

  tt_regs #(.CNT_W(CNT_W), .DIV_W(DIV_W)) u_regs (
    .clk(clk), .rst_n(rst_ni), .wr(bus_wr), .rd(bus_rd), .addr(bus_addr),
    .wdata(bus_wdata), .rdata(bus_rdata), .wrap(wrap), .cnt(cnt),
    .run(run), .force_upd(force_upd), .div_act(div_act),
    .rld_act(rld_act), .irq(irq)
  );

  tt_prescaler #(.DIV_W(DIV_W)) u_div (
    .clk(clk), .rst_n(rst_ni), .run(run), .force_upd(force_upd),
    .div_act(div_act), .tick(tick)
  );

  tt_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_ni), .tick(tick), .force_upd(force_upd),
    .rld_act(rld_act), .cnt(cnt), .wrap(wrap)
  );
endmodule

// File: tb/sim_tick_timer.sv
`timescale 1ns/1ps
module sim_tick_timer;
  localparam int CNT_W = 32;
  localparam int NV = 5;
  localparam int unsigned V_DIV [NV] = '{0, 0, 2, 4, 1};
  localparam int unsigned V_RLD [NV] = '{1, 3, 3, 0, 5};
  localparam int unsigned V_ONE [NV] = '{1, 1, 0, 1, 0};
  localparam int unsigned V_EXP [NV] = '{2, 4, 12, 5, 12};

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [31:0] bus_rdata;
  logic        irq;
  int          n_chk = 0, n_bad = 0;
  logic [31:0] v, v2;
  int          n;

  always #2 clk = ~clk;

  tick_timer #(.CNT_W(CNT_W)) u0 (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_rdata(bus_rdata), .irq(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    bus_addr = a; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic wait_irq(output int cnt);
    cnt = 0;
    while (!irq && cnt < 2000) begin
      @(negedge clk);
      cnt++;
    end
  endtask

  task automatic prime(input logic [31:0] dv, input logic [31:0] rl);
    wr(3'd0, 32'h0);
    wr(3'd4, dv);
    wr(3'd5, rl);
    wr(3'd3, 32'h1);
    wr(3'd2, 32'h0);
    wr(3'd1, 32'h1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    chk("R1 irq", {31'd0, irq}, 32'd0);
    rd(3'd0, v); chk("R1 ctrl", v, 32'h0);
    rd(3'd2, v); chk("R1 status", v, 32'h0);
    rd(3'd5, v); chk("R1 reload", v, 32'h0);
    rd(3'd6, v); chk("R1 count", v, 32'h0);

    // R2 R3 R4 vector table
    for (int i = 0; i < NV; i++) begin
      prime(V_DIV[i], V_RLD[i]);
      wr(3'd0, (V_ONE[i] != 0) ? 32'h09 : 32'h01);
      wait_irq(n);
      chk("R2 period", n, V_EXP[i]);
      rd(3'd6, v); chk("R3 wrap count", v, 32'h0);
      rd(3'd2, v); chk("R3 flag", v, 32'h1);
      rd(3'd0, v);
      if (V_ONE[i] != 0) chk("R4 single-shot ctrl", v, 32'h08);
      else               chk("R3 periodic ctrl", v, 32'h01);
    end

    // R5 preload shadow
    prime(0, 3);
    wr(3'd0, 32'h80);
    wr(3'd5, 32'd7);
    rd(3'd5, v); chk("R5 shadow readback", v, 32'd7);
    wr(3'd0, 32'h81);
    wait_irq(n); chk("R5 old period", n, 32'd4);
    wr(3'd2, 32'h0);
    wait_irq(n); chk("R5 new period", n, 32'd7);

    // R9 stop holds count
    prime(0, 100);
    wr(3'd0, 32'h01);
    repeat (5) @(negedge clk);
    wr(3'd0, 32'h0);
    rd(3'd6, v); chk("R9 count at stop", v, 32'd6);
    repeat (3) @(negedge clk);
    rd(3'd6, v2); chk("R9 count held", v2, v);

    // R6 forced update
    wr(3'd2, 32'h0);
    wr(3'd3, 32'h1);
    rd(3'd6, v); chk("R6 count cleared", v, 32'h0);
    rd(3'd2, v); chk("R6 flag set", v, 32'h1);
    rd(3'd3, v); chk("R6 event reads zero", v, 32'h0);

    // R7 interrupt gating
    wr(3'd1, 32'h0);
    chk("R7 irq masked", {31'd0, irq}, 32'd0);
    wr(3'd1, 32'h1);
    chk("R7 irq enabled", {31'd0, irq}, 32'd1);
    wr(3'd2, 32'hFFFF_FFFE);
    chk("R7 irq cleared", {31'd0, irq}, 32'd0);

    // R8 width readback
    wr(3'd5, 32'hFFFF_FFFF);
    rd(3'd5, v); chk("R8 width", v, 32'((64'd1 << CNT_W) - 1));

    // R10 unused bits
    wr(3'd0, 32'hFFFF_FF76);
    rd(3'd0, v); chk("R10 ctrl unused", v, 32'h0);
    wr(3'd1, 32'hFFFF_FFFF);
    rd(3'd1, v); chk("R10 ien unused", v, 32'h1);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule